// File: doc/BRIEF.md
# Flash Self-Programming Control Register

This block is the CPU-visible control word that arms flash self-programming. Software writes a command bit together with an enable bit. That opens a short window counted in clock cycles. A store strobe arriving inside the window starts a page erase or a page write. A load strobe arriving inside the window returns fuse or lock bits. Writing a command bit with the enable bit also lets software discard the temporary page buffer.

If no strobe arrives before the window closes, the armed bits clear themselves. Once an erase or write starts, the block drives a one-cycle command to the flash timing engine and holds the CPU halted. It keeps the halt until the engine returns a done pulse, and then clears the command and enable bits. The page address is taken from the high part of the address pointer, and bit 0 of the pointer chooses between fuse and lock bits.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset every register bit reads 0 and all outputs are low. Bits 7:5 of `reg_rdata` always read 0. The readable layout is bit 0 enable, bit 1 erase, bit 2 write, bit 3 fuse/lock read and bit 4 buffer clear.
- R2: A write whose bit 0 (enable) is 0 arms nothing, and the register reads 0x00 afterwards.
- R3: A write with bits 1 and 0 set arms erase (reads 0x03). A write with bits 2 and 0 set arms write (reads 0x05). A store strobe sampled on any of the 4 clock edges after the write edge starts the operation. On the edge that samples the strobe, the block registers a one-cycle `cmd_erase` or `cmd_write` pulse with `cmd_page` equal to `ptr_page`.
- R4: If no store strobe arrives, an armed erase or write reads unchanged for 3 cycles after the write and reads 0x00 from the 4th edge on. A later store strobe starts nothing.
- R5: `cpu_halt` rises in the cycle of the command pulse and stays high until the edge that samples `eng_done`.
- R6: On completion the command bit and the enable bit clear together, and the register reads 0x00.
- R7: While `cpu_halt` is high, register writes are ignored.
- R8: A write of 0x09 arms a fuse/lock read. A load strobe on any of the 3 edges after the write edge registers a one-cycle `rd_stb` with `rd_lock = ptr_lsb` (1 selects lock bits, 0 selects fuse bits). With no strobe, the register reads 0x00 from the 3rd edge on.
- R9: A write of 0x11 registers a one-cycle `buf_clear` pulse in the cycle after the write edge, during which the register reads 0x11. The register reads 0x00 in the cycle after that. A write of 0x10 without enable clears nothing.
- R10: When several command bits are written with enable, only one is kept, with priority erase > write > fuse/lock read > buffer clear. For example, 0x0F reads 0x03, 0x0D reads 0x05 and 0x19 reads 0x09.
- R11: A store strobe with no erase or write armed, including enable alone (0x01), produces no command and no halt.
- R12: The block holds the halt for any engine busy time from 3.7 ms to 4.5 ms. The halt lasts the engine's busy cycles plus one.

Each write is sampled on a clock edge, called the write edge below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 5 | Writable control bits 4:0 |
| reg_rdata | output | 8 | Register read value |
| spm_stb | input | 1 | Store-to-program-memory strobe |
| lpm_stb | input | 1 | Load-from-program-memory strobe |
| ptr_page | input | PAGE_W | High (page) part of the address pointer |
| ptr_lsb | input | 1 | Address pointer bit 0, fuse/lock select |
| eng_done | input | 1 | Completion pulse from the flash timing engine |
| cmd_erase | output | 1 | One-cycle page erase command |
| cmd_write | output | 1 | One-cycle page write command |
| cmd_page | output | PAGE_W | Page address captured at start |
| buf_clear | output | 1 | One-cycle page buffer clear |
| cpu_halt | output | 1 | CPU halt during erase or write |
| rd_stb | output | 1 | One-cycle fuse/lock read request |
| rd_lock | output | 1 | Read select: 1 lock bits, 0 fuse bits |

## Verification
The outputs have different latencies, and each check samples at the one that applies:

- **Command and read pulses:** due in the cycle right after the edge that samples the strobe.
- **Buffer-clear pulse:** due in the cycle right after the write edge.
- **Register contents:** change on the write edge, on the window's last edge and on the edge that samples `eng_done`. The halt ends on that same done edge.

Expected pulses go into a scoreboard queue tagged with the bench's cycle number. A monitor sampling on the falling edge compares kind, data and cycle, and flags any pulse it did not expect. Register reads are taken on falling edges at the window limits, on both sides of the timeout edge.

// File: rtl/fspm_pkg.sv
package fspm_pkg;
  localparam int CTL_W = 5;
  localparam int REG_W = 8;

  typedef struct packed {
    logic clr_buf;
    logic rd_fl;
    logic pg_write;
    logic pg_erase;
    logic enable;
  } fspm_ctl_t;
endpackage

// File: rtl/fspm_decode.sv
module fspm_decode
  import fspm_pkg::*;
(
  input  logic [CTL_W-1:0] wdata,
  output fspm_ctl_t        ctl_n,
  output logic             sel_rd
);
  always_comb begin
    ctl_n = '0;
    if (wdata[0]) begin
      ctl_n.enable = 1'b1;
      if (wdata[1])      ctl_n.pg_erase = 1'b1;
      else if (wdata[2]) ctl_n.pg_write = 1'b1;
      else if (wdata[3]) ctl_n.rd_fl    = 1'b1;
      else if (wdata[4]) ctl_n.clr_buf  = 1'b1;
    end
    sel_rd = ctl_n.rd_fl;
  end
endmodule

// File: rtl/fspm_window.sv
module fspm_window #(
  parameter int ARM_WIN = 4,
  parameter int RD_WIN  = 3,
  parameter int WIN_W   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic sel_rd,
  input  logic run,
  output logic expire
);
  logic [WIN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= sel_rd ? WIN_W'(RD_WIN) : WIN_W'(ARM_WIN);
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire = run && (cnt_q == WIN_W'(1));
endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import fspm_pkg::*;
#(
  parameter int PAGE_W  = 11,
  parameter int ARM_WIN = 4,
  parameter int RD_WIN  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [CTL_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              spm_stb,
  input  logic              lpm_stb,
  input  logic [PAGE_W-1:0] ptr_page,
  input  logic              ptr_lsb,
  input  logic              eng_done,
  output logic              cmd_erase,
  output logic              cmd_write,
  output logic [PAGE_W-1:0] cmd_page,
  output logic              buf_clear,
  output logic              cpu_halt,
  output logic              rd_stb,
  output logic              rd_lock
);
  localparam int WIN_MAX = (ARM_WIN > RD_WIN) ? ARM_WIN : RD_WIN;
  localparam int WIN_W   = $clog2(WIN_MAX + 1);

  fspm_ctl_t ctl_q;
  fspm_ctl_t ctl_n;
  logic      sel_rd;
  logic      busy_q;
  logic      win_load;
  logic      win_run;
  logic      expire;

  fspm_decode u_dec (
    .wdata  (reg_wdata),
    .ctl_n  (ctl_n),
    .sel_rd (sel_rd)
  );

  assign win_load = reg_we && !busy_q;
  assign win_run  = ctl_q.enable && !busy_q;

  fspm_window #(
    .ARM_WIN (ARM_WIN),
    .RD_WIN  (RD_WIN),
    .WIN_W   (WIN_W)
  ) u_win (
    .clk    (clk),
    .rst    (rst),
    .load   (win_load),
    .sel_rd (sel_rd),
    .run    (win_run),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      busy_q    <= 1'b0;
      cmd_erase <= 1'b0;
      cmd_write <= 1'b0;
      cmd_page  <= '0;
      buf_clear <= 1'b0;
      rd_stb    <= 1'b0;
      rd_lock   <= 1'b0;
    end else begin
      cmd_erase <= 1'b0;
      cmd_write <= 1'b0;
      buf_clear <= 1'b0;
      rd_stb    <= 1'b0;
      if (busy_q) begin
        // operation in flight: writes ignored, wait for the engine
        if (eng_done) begin
          busy_q <= 1'b0;
          ctl_q  <= '0;
        end
      end else if (reg_we) begin
        ctl_q     <= ctl_n;
        buf_clear <= ctl_n.clr_buf;
      end else if (ctl_q.enable) begin
        if ((ctl_q.pg_erase || ctl_q.pg_write) && spm_stb) begin
          busy_q    <= 1'b1;
          cmd_erase <= ctl_q.pg_erase;
          cmd_write <= ctl_q.pg_write;
          cmd_page  <= ptr_page;
        end else if (ctl_q.rd_fl && lpm_stb) begin
          rd_stb  <= 1'b1;
          rd_lock <= ptr_lsb;
          ctl_q   <= '0;
        end else if (ctl_q.clr_buf || expire) begin
          ctl_q <= '0;
        end
      end
    end
  end

  assign cpu_halt  = busy_q;
  assign reg_rdata = {{(REG_W-CTL_W){1'b0}}, ctl_q};
endmodule

// File: rtl/fspm_checker.sv
module fspm_checker (
  input logic       clk,
  input logic       rst,
  input logic       reg_we,
  input logic       wr_en_bit,
  input logic [7:0] reg_rdata,
  input logic       spm_stb,
  input logic       lpm_stb,
  input logic       eng_done,
  input logic       cmd_erase,
  input logic       cmd_write,
  input logic       buf_clear,
  input logic       cpu_halt,
  input logic       rd_stb
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[7:5] == 3'b000);

  a_r10_one_pulse: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_erase, cmd_write, rd_stb, buf_clear}));

  a_r2_no_enable: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !cpu_halt && !wr_en_bit) |=> (reg_rdata == 8'h00));

  a_r5_halt_with_cmd: assert property (@(posedge clk) disable iff (rst)
    (cmd_erase || cmd_write) |-> cpu_halt);

  a_r5_halt_hold: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt && !eng_done) |=> cpu_halt);

  a_r6_done_clears: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt && eng_done) |=> (!cpu_halt && reg_rdata == 8'h00));

  a_r7_busy_frozen: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt && !eng_done) |=> $stable(reg_rdata));

  a_r8_read_after_load: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> $past(lpm_stb));

  a_r11_idle_store: assert property (@(posedge clk) disable iff (rst)
    (!reg_rdata[0] && !cpu_halt && !reg_we && spm_stb) |=> (!cmd_erase && !cmd_write));
endmodule

bind flash_selfprog_ctrl fspm_checker u_fspm_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .wr_en_bit (reg_wdata[0]),
  .reg_rdata (reg_rdata),
  .spm_stb   (spm_stb),
  .lpm_stb   (lpm_stb),
  .eng_done  (eng_done),
  .cmd_erase (cmd_erase),
  .cmd_write (cmd_write),
  .buf_clear (buf_clear),
  .cpu_halt  (cpu_halt),
  .rd_stb    (rd_stb)
);

// File: tb/tb_flash_selfprog_ctrl.sv
`timescale 1ns/1ps
module tb_flash_selfprog_ctrl;
  localparam int CLK_PERIOD = 25000;  // 25 us
  localparam int PAGE_W     = 11;
  localparam int K_ERASE = 1, K_WRITE = 2, K_READ = 3, K_CLEAR = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_we = 1'b0;
  logic [4:0]        reg_wdata = '0;
  logic [7:0]        reg_rdata;
  logic              spm_stb = 1'b0;
  logic              lpm_stb = 1'b0;
  logic [PAGE_W-1:0] ptr_page = '0;
  logic              ptr_lsb = 1'b0;
  logic              eng_done;
  logic              cmd_erase, cmd_write, buf_clear, cpu_halt, rd_stb, rd_lock;
  logic [PAGE_W-1:0] cmd_page;

  flash_selfprog_ctrl #(.PAGE_W(PAGE_W)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spm_stb(spm_stb), .lpm_stb(lpm_stb),
    .ptr_page(ptr_page), .ptr_lsb(ptr_lsb), .eng_done(eng_done),
    .cmd_erase(cmd_erase), .cmd_write(cmd_write), .cmd_page(cmd_page),
    .buf_clear(buf_clear), .cpu_halt(cpu_halt), .rd_stb(rd_stb),
    .rd_lock(rd_lock)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // flash engine model: busy counter started by a command pulse
  int busy_len = 160;
  int ecnt = 0;
  always @(posedge clk) begin
    if (rst)                         ecnt <= 0;
    else if (cmd_erase || cmd_write) ecnt <= busy_len;
    else if (ecnt != 0)              ecnt <= ecnt - 1;
  end
  assign eng_done = (ecnt == 1);

  typedef struct {
    int    kind;
    int    data;
    int    due;
    string req;
  } exp_t;
  exp_t sbq[$];

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int data, input int due, input string req);
    exp_t e;
    e.kind = kind; e.data = data; e.due = due; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic got(input int kind, input int data);
    exp_t e;
    if (sbq.size() == 0) begin
      chk(1'b0, "R11", "unexpected pulse kind", kind, 0);
    end else begin
      e = sbq.pop_front();
      chk(e.kind == kind, e.req, "pulse kind", kind, e.kind);
      chk(e.data == data, e.req, "pulse data", data, e.data);
      chk(e.due == cyc, e.req, "pulse cycle", cyc, e.due);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_erase) got(K_ERASE, int'(cmd_page));
      if (cmd_write) got(K_WRITE, int'(cmd_page));
      if (rd_stb)    got(K_READ, int'(rd_lock));
      if (buf_clear) got(K_CLEAR, 0);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] d);
    reg_we = 1'b1; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic spm_at(input int k);
    for (int i = 1; i < k; i++) tick();
    spm_stb = 1'b1; tick(); spm_stb = 1'b0;
  endtask

  task automatic lpm_at(input int k);
    for (int i = 1; i < k; i++) tick();
    lpm_stb = 1'b1; tick(); lpm_stb = 1'b0;
  endtask

  task automatic wait_halt(output int n);
    n = 0;
    while (cpu_halt && n < 1000) begin tick(); n++; end
  endtask

  task automatic rd_is(input logic [7:0] exp, input string req);
    chk(reg_rdata == exp, req, "register", int'(reg_rdata), int'(exp));
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R5", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    int n;
    repeat (3) tick();
    rd_is(8'h00, "R1");
    chk({cmd_erase, cmd_write, buf_clear, rd_stb, cpu_halt} == 5'b0, "R1",
        "outputs in reset", int'({cmd_erase, cmd_write, buf_clear, rd_stb, cpu_halt}), 0);
    rst = 1'b0;
    tick();
    rd_is(8'h00, "R1");

    // R3 erase, strobe on first edge; R5/R6 halt and completion
    ptr_page = 11'h55E;
    wr(5'h03); rd_is(8'h03, "R3");
    push(K_ERASE, 'h55E, cyc + 1, "R3");
    spm_at(1);
    chk(cpu_halt, "R5", "halt with command", int'(cpu_halt), 1);
    wait_halt(n);
    chk(n == busy_len + 1, "R5", "halt cycles", n, busy_len + 1);
    rd_is(8'h00, "R6");

    // R3 write, strobe on 4th edge; R7 write ignored while busy
    ptr_page = 11'h091;
    wr(5'h05);
    push(K_WRITE, 'h091, cyc + 4, "R3");
    spm_at(4);
    repeat (10) tick();
    rd_is(8'h05, "R7");
    wr(5'h03); tick();
    rd_is(8'h05, "R7");
    wait_halt(n);
    rd_is(8'h00, "R6");
    repeat (6) tick();
    chk(!cpu_halt, "R7", "no restart after ignored write", int'(cpu_halt), 0);

    // R4 timeout for erase and write
    wr(5'h03);
    repeat (3) tick(); rd_is(8'h03, "R4");
    tick();            rd_is(8'h00, "R4");
    spm_at(1); tick();
    chk(!cpu_halt, "R4", "late store ignored", int'(cpu_halt), 0);
    wr(5'h05);
    repeat (3) tick(); rd_is(8'h05, "R4");
    tick();            rd_is(8'h00, "R4");

    // R8 fuse/lock read
    ptr_lsb = 1'b1;
    wr(5'h09); rd_is(8'h09, "R8");
    push(K_READ, 1, cyc + 3, "R8");
    lpm_at(3);
    rd_is(8'h00, "R8");
    ptr_lsb = 1'b0;
    wr(5'h09);
    push(K_READ, 0, cyc + 1, "R8");
    lpm_at(1);
    wr(5'h09);
    repeat (2) tick(); rd_is(8'h09, "R8");
    tick();            rd_is(8'h00, "R8");
    lpm_at(1);

    // R9 buffer clear
    push(K_CLEAR, 0, cyc + 1, "R9");
    wr(5'h11); rd_is(8'h11, "R9");
    tick();    rd_is(8'h00, "R9");
    wr(5'h10); rd_is(8'h00, "R9");
    tick();

    // R10 priority
    ptr_page = 11'h7FF;
    wr(5'h0F); rd_is(8'h03, "R10");
    push(K_ERASE, 'h7FF, cyc + 2, "R10");
    spm_at(2);
    wait_halt(n);
    ptr_page = 11'h001;
    wr(5'h0D); rd_is(8'h05, "R10");
    lpm_at(1);
    push(K_WRITE, 'h001, cyc + 1, "R10");
    spm_at(1);
    wait_halt(n);
    wr(5'h19); rd_is(8'h09, "R10");
    push(K_READ, 0, cyc + 1, "R10");
    lpm_at(1);

    // R11 store with nothing armed
    wr(5'h01);
    spm_at(1);
    rd_is(8'h01, "R11");
    chk(!cpu_halt, "R11", "enable-only store", int'(cpu_halt), 0);
    repeat (3) tick(); rd_is(8'h00, "R11");
    spm_at(1); tick();
    chk(!cpu_halt, "R11", "idle store", int'(cpu_halt), 0);

    // R2 no enable
    wr(5'h06); rd_is(8'h00, "R2");
    spm_at(1); tick();
    chk(!cpu_halt, "R2", "unarmed store", int'(cpu_halt), 0);

    // R12 busy time limits
    for (int j = 0; j < 2; j++) begin
      busy_len = (j == 0) ? 148 : 179;
      wr(5'h03);
      push(K_ERASE, 'h001, cyc + 1, "R12");
      spm_at(1);
      wait_halt(n);
      chk(n == busy_len + 1, "R12", "halt cycles", n, busy_len + 1);
      chk(n * CLK_PERIOD >= 3700000 && n * CLK_PERIOD <= 4500000, "R12",
          "halt time ns", n * CLK_PERIOD, 4000000);
      rd_is(8'h00, "R12");
    end

    repeat (5) tick();
    chk(sbq.size() == 0, "R3", "missing pulses", sbq.size(), 0);
    summary();
  end
endmodule